// File: doc/BRIEF.md
# Half-Duplex Inter-Packet Gap Deferral Controller

This block decides the moment at which a MAC transmitter may begin a frame. It times the inter-packet gap (IPG) in byte times, using a clock-enable input (`byte_tick`) that pulses once per byte time. The rate of that pulse is set outside the block and depends on the selected line speed. After the block's own frame ends, it uses a back-to-back gap length. In half-duplex operation it also defers to foreign carrier. When that carrier ends, it times a longer non-back-to-back gap.

The non-back-to-back gap has two parts. While the count is still inside the first part, any carrier resets the count to zero. Once the count reaches the second part, carrier is ignored, and a pending request is granted when the gap expires. Half-duplex deferral applies only at 10 and 100 Mbps. With the gigabit select high, the block behaves as full-duplex and never looks at carrier or collision.

The grant, once given, stays high until the end-of-transmission pulse. Backoff, jam, retry counting and the data path belong to other blocks.

Top module: `ipg_defer_ctrl`

## Requirements
- R1: After reset `tx_grant` is low and the block is ready: a request made with no carrier is granted in the cycle after it is sampled.
- R2: In full-duplex mode (`half_duplex`=0), `crs` and `col` have no effect: a request made in the ready state is granted in the next cycle even with both high.
- R3: With `speed_gig`=1 the block behaves as full-duplex even when `half_duplex`=1, so a request is granted in the next cycle while `crs` is high.
- R4: Once `tx_grant` is high it stays high, whether or not `tx_req` is still present, until `tx_done` is sampled high. It is low in the following cycle.
- R5: After `tx_done`, a pending request is granted in the cycle after the `byte_tick` that completes `cfg_bb_len` ticks (at least one tick), and not before.
- R6: In effective half-duplex mode, a request made while carrier is present (`crs` or `col` high) is not granted. Gap timing begins in the cycle after carrier is sampled low.
- R7: After foreign carrier ends, a pending request is granted in the cycle after the tick that completes `cfg_nbb_len` ticks.
- R8: Carrier sampled while the gap count is below `cfg_p1_len` (the first part) clears the count to zero. Another full `cfg_nbb_len` ticks are then needed.
- R9: Carrier that appears once the count has reached `cfg_p1_len` (the second part) is ignored. The grant is given at expiry even with `crs` high.
- R10: The gap count advances only on cycles where `byte_tick` is high. Without ticks no gap expires and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | One-cycle pulse per byte time at the current speed |
| half_duplex | input | 1 | 1 selects half-duplex operation |
| speed_gig | input | 1 | 1 selects 1000 Mbps, which forces full-duplex behaviour |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision indication from the PHY |
| tx_req | input | 1 | Transmitter requests to start a frame |
| tx_done | input | 1 | Pulse marking the end of the block's own transmission |
| cfg_p1_len | input | CNT_W | First-part length of the non-back-to-back gap, in byte times |
| cfg_nbb_len | input | CNT_W | Total non-back-to-back gap length, in byte times (12 gives 96 bit times) |
| cfg_bb_len | input | CNT_W | Back-to-back gap length, in byte times (12 gives 96 bit times) |
| tx_grant | output | 1 | The transmitter may start; held until `tx_done` |

## Verification
Several rules are checked by assertions on every cycle:
- the grant is held until the end pulse;
- a grant only follows a request;
- in full-duplex mode a request in the ready state is granted at once;
- half-duplex carrier blocks the grant;
- carrier in the first part clears the count;
- the count stays still without a tick.

The exact gap lengths need the bench's scenarios, with random lengths and tick spacing. These include the back-to-back and non-back-to-back totals, the restart after a first-part carrier pulse, and the grant under carrier in the second part. The forcing of full-duplex behaviour at gigabit speed is also shown only by the bench.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;
   typedef enum logic [2:0] {
      ST_READY = 3'd0,
      ST_GRANT = 3'd1,
      ST_BB    = 3'd2,
      ST_WAIT  = 3'd3,
      ST_NBB   = 3'd4
   } defer_state_t;
endpackage

// File: rtl/ipg_mode_sel.sv
module ipg_mode_sel #(
   parameter bit COL_AS_CARRIER = 1'b1
) (
   input  logic half_duplex,
   input  logic speed_gig,
   input  logic crs,
   input  logic col,
   output logic hd_eff,
   output logic carrier
);
   // Half-duplex deferral exists only below gigabit speed
   assign hd_eff = half_duplex & ~speed_gig;

   generate
      if (COL_AS_CARRIER) begin : g_col_carrier
         assign carrier = crs | col;
      end else begin : g_crs_only
         logic unused_col;
         assign unused_col = col;
         assign carrier = crs;
      end
   endgenerate
endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             byte_tick,
   input  logic             count_en,
   input  logic [CNT_W-1:0] gap_len,
   input  logic [CNT_W-1:0] part1_len,
   output logic [CNT_W-1:0] cnt,
   output logic             last_step,
   output logic             in_part1
);
   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] cnt_next_ext;

   assign cnt_next_ext = {1'b0, cnt} + EXT_W'(1);
   assign last_step    = cnt_next_ext >= {1'b0, gap_len};
   assign in_part1     = cnt < part1_len;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + CNT_W'(1);
   end

   // R10: the count is frozen on cycles without a byte tick
   p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !byte_tick && !clr) |=> $stable(cnt));

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 16) else $error("CNT_W out of range");
   end
endmodule

// File: rtl/ipg_defer_ctrl.sv
module ipg_defer_ctrl
   import ipg_defer_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter bit COL_AS_CARRIER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_tick,
   input  logic             half_duplex,
   input  logic             speed_gig,
   input  logic             crs,
   input  logic             col,
   input  logic             tx_req,
   input  logic             tx_done,
   input  logic [CNT_W-1:0] cfg_p1_len,
   input  logic [CNT_W-1:0] cfg_nbb_len,
   input  logic [CNT_W-1:0] cfg_bb_len,
   output logic             tx_grant
);
   defer_state_t     st, st_nxt;
   logic             hd_eff, carrier;
   logic             t_clr, t_inc, last_step, in_part1, count_en;
   logic [CNT_W-1:0] gap_len, cnt;

   ipg_mode_sel #(.COL_AS_CARRIER(COL_AS_CARRIER)) i_mode (
      .half_duplex(half_duplex), .speed_gig(speed_gig),
      .crs(crs), .col(col), .hd_eff(hd_eff), .carrier(carrier)
   );

   assign gap_len  = (st == ST_BB) ? cfg_bb_len : cfg_nbb_len;
   assign count_en = (st == ST_BB) || (st == ST_NBB);

   ipg_gap_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc),
      .byte_tick(byte_tick), .count_en(count_en),
      .gap_len(gap_len), .part1_len(cfg_p1_len),
      .cnt(cnt), .last_step(last_step), .in_part1(in_part1)
   );

   always_comb begin
      st_nxt = st;
      t_clr  = 1'b0;
      t_inc  = 1'b0;
      unique case (st)
         ST_READY: begin
            if (hd_eff && carrier) st_nxt = ST_WAIT;
            else if (tx_req)       st_nxt = ST_GRANT;
         end
         ST_GRANT: begin
            if (tx_done) begin
               st_nxt = ST_BB;
               t_clr  = 1'b1;
            end
         end
         ST_BB: begin
            if (byte_tick) begin
               if (last_step) st_nxt = tx_req ? ST_GRANT : ST_READY;
               else           t_inc  = 1'b1;
            end
         end
         ST_WAIT: begin
            if (!hd_eff) st_nxt = ST_READY;
            else if (!carrier) begin
               st_nxt = ST_NBB;
               t_clr  = 1'b1;
            end
         end
         ST_NBB: begin
            if (!hd_eff)                    st_nxt = ST_READY;
            else if (carrier && in_part1)   t_clr  = 1'b1;
            else if (byte_tick) begin
               if (last_step) st_nxt = tx_req ? ST_GRANT : ST_READY;
               else           t_inc  = 1'b1;
            end
         end
         default: st_nxt = ST_READY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_READY;
      else        st <= st_nxt;
   end

   assign tx_grant = (st == ST_GRANT);

   // R4: grant held until the end-of-transmission pulse
   p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_grant && !tx_done) |=> tx_grant);
   // R4: grant released after the end pulse
   p_grant_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_grant && tx_done) |=> !tx_grant);
   // R1: a grant is only ever given to a request
   p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_grant) |-> $past(tx_req));
   // R2: full-duplex request in the ready state is granted at once
   p_fd_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hd_eff && st == ST_READY && tx_req) |=> tx_grant);
   // R6: half-duplex carrier blocks a request from the ready state
   p_carrier_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hd_eff && carrier && st == ST_READY) |=> !tx_grant);
   // R8: carrier in the first part restarts the count
   p_part1_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NBB && hd_eff && carrier && in_part1) |=> (cnt == '0));

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 16) else $error("CNT_W out of range");
   end
endmodule

// File: tb/test_ipg_defer_ctrl.sv
`timescale 1ns/1ps
module test_ipg_defer_ctrl;
   localparam int W = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic byte_tick = 0, half_duplex = 0, speed_gig = 0, crs = 0, col = 0;
   logic tx_req = 0, tx_done = 0;
   logic [W-1:0] cfg_p1_len = 8, cfg_nbb_len = 12, cfg_bb_len = 12;
   logic tx_grant;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   ipg_defer_ctrl #(.CNT_W(W)) i_ipg_defer_ctrl (
      .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick),
      .half_duplex(half_duplex), .speed_gig(speed_gig),
      .crs(crs), .col(col), .tx_req(tx_req), .tx_done(tx_done),
      .cfg_p1_len(cfg_p1_len), .cfg_nbb_len(cfg_nbb_len),
      .cfg_bb_len(cfg_bb_len), .tx_grant(tx_grant)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   // ticks needed for a gap of the given length (at least one)
   function automatic int exp_gap(input int len);
      return (len == 0) ? 1 : len;
   endfunction

   // issue ticks with random spacing until grant; return ticks used
   task automatic gap_run(output int ticks);
      ticks = 0;
      for (int k = 0; k < 300; k++) begin
         byte_tick = 1'b1;
         step;
         byte_tick = 1'b0;
         ticks++;
         if (tx_grant) return;
         repeat ($urandom % 3) step;
      end
   endtask

   task automatic finish_tx;
      tx_done = 1'b1;
      step;
      tx_done = 1'b0;
   endtask

   task automatic settle_ready;
      tx_req = 1'b0;
      repeat (int'(cfg_bb_len) + 2) begin
         byte_tick = 1'b1;
         step;
      end
      byte_tick = 1'b0;
      step;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int t;
      void'($urandom(32'h5eed_1234));
      repeat (4) step;
      chk(tx_grant == 1'b0, "R1 reset grant", tx_grant, 0);
      rst_n = 1'b1;
      step;
      tx_req = 1'b1;
      step;
      chk(tx_grant == 1'b1, "R1 first grant", tx_grant, 1);

      // R4: hold without request, release after end pulse
      tx_req = 1'b0;
      repeat (3) step;
      chk(tx_grant == 1'b1, "R4 hold", tx_grant, 1);
      finish_tx;
      chk(tx_grant == 1'b0, "R4 release", tx_grant, 0);

      // R10: no ticks, no expiry
      tx_req = 1'b1;
      repeat (30) step;
      chk(tx_grant == 1'b0, "R10 no tick", tx_grant, 0);
      gap_run(t);
      chk(t == exp_gap(cfg_bb_len), "R5 bb gap", t, exp_gap(cfg_bb_len));

      // R5: random back-to-back lengths and tick spacing
      for (int i = 0; i < 16; i++) begin
         cfg_bb_len = W'(1 + $urandom % 24);
         finish_tx;
         gap_run(t);
         chk(t == exp_gap(cfg_bb_len), "R5 random bb", t, exp_gap(cfg_bb_len));
      end
      cfg_bb_len = 0;
      finish_tx;
      gap_run(t);
      chk(t == 1, "R5 zero length", t, 1);
      cfg_bb_len = 12;

      // R2: full duplex ignores carrier and collision
      finish_tx;
      settle_ready;
      crs = 1'b1; col = 1'b1; tx_req = 1'b1;
      step;
      chk(tx_grant == 1'b1, "R2 fd ignores crs/col", tx_grant, 1);
      crs = 1'b0; col = 1'b0;
      finish_tx;

      // R3: gigabit forces full-duplex
      settle_ready;
      half_duplex = 1'b1; speed_gig = 1'b1; crs = 1'b1; tx_req = 1'b1;
      step;
      chk(tx_grant == 1'b1, "R3 gig ignores crs", tx_grant, 1);
      crs = 1'b0; speed_gig = 1'b0;
      finish_tx;

      // R6 / R7: carrier blocks, then non-back-to-back gap
      settle_ready;
      crs = 1'b1; tx_req = 1'b1;
      repeat (6) step;
      chk(tx_grant == 1'b0, "R6 crs blocks", tx_grant, 0);
      crs = 1'b0; col = 1'b1;
      repeat (3) step;
      chk(tx_grant == 1'b0, "R6 col blocks", tx_grant, 0);
      col = 1'b0;
      step;
      gap_run(t);
      chk(t == exp_gap(cfg_nbb_len), "R7 nbb gap", t, exp_gap(cfg_nbb_len));
      finish_tx;

      // R8: carrier in the first part restarts the count
      settle_ready;
      crs = 1'b1; tx_req = 1'b1;
      repeat (2) step;
      crs = 1'b0;
      step;
      for (int k = 0; k < 4; k++) begin
         byte_tick = 1'b1;
         step;
      end
      byte_tick = 1'b0;
      chk(tx_grant == 1'b0, "R8 no grant yet", tx_grant, 0);
      crs = 1'b1;
      step;
      crs = 1'b0;
      step;
      gap_run(t);
      chk(t == exp_gap(cfg_nbb_len), "R8 restart", t, exp_gap(cfg_nbb_len));
      finish_tx;

      // R9: carrier in the second part is ignored
      settle_ready;
      crs = 1'b1; tx_req = 1'b1;
      repeat (2) step;
      crs = 1'b0;
      step;
      for (int k = 0; k < int'(cfg_p1_len); k++) begin
         byte_tick = 1'b1;
         step;
      end
      byte_tick = 1'b0;
      crs = 1'b1;
      gap_run(t);
      chk(t == int'(cfg_nbb_len) - int'(cfg_p1_len), "R9 part two", t,
          int'(cfg_nbb_len) - int'(cfg_p1_len));
      chk(tx_grant == 1'b1 && crs == 1'b1, "R9 grant under crs", tx_grant, 1);
      crs = 1'b0;
      finish_tx;

      // R7: random two-part lengths
      for (int i = 0; i < 10; i++) begin
         cfg_p1_len  = W'(1 + $urandom % 10);
         cfg_nbb_len = cfg_p1_len + W'(1 + $urandom % 10);
         settle_ready;
         crs = 1'b1; tx_req = 1'b1;
         step;
         crs = 1'b0;
         step;
         gap_run(t);
         chk(t == exp_gap(cfg_nbb_len), "R7 random nbb", t, exp_gap(cfg_nbb_len));
         finish_tx;
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule